// File: doc/BRIEF.md
# Cycle-Based Current Fault Controller

This block supervises the switching of a step-down regulator once per switching period. Two comparator flags come in: one trips when the high-side switch current is too large, the other when the low-side valley current goes too far negative. A one-clock `cyc_start` pulse marks the start of each switching period. The flags seen during a period are accumulated, and at the following `cyc_start` the period is closed and judged.

An overcurrent trip blanks the high-side gate enable at once for the rest of the period. Seventeen back-to-back overcurrent periods put the regulator into a hiccup hold. The hold lasts eight soft-start ticks, then the counters clear and a soft-start restart is requested. Four back-to-back negative-current periods stop both switches and enable the output discharge path. When the output is back in regulation, switching resumes in PFM for a dwell of twenty microsecond ticks.

Top module: `cycle_fault_ctrl`

## Requirements
- R1: While `oc_trip` is high in normal operation, `hs_en` is low in the same clock. `hs_en` stays low for the rest of that switching period and returns high only after the next `cyc_start` has been sampled.
- R2: When 17 consecutive switching periods each hold at least one `oc_trip`, the `cyc_start` that closes the 17th period moves the block into hiccup. In hiccup, `hiccup`=1, `fault_active`=1, `hs_en`=0 and `ls_en`=0. Sixteen such periods are not enough.
- R3: A period with no `oc_trip` clears the overcurrent run. Sixteen trip periods, one clean period and then sixteen more trip periods do not cause hiccup.
- R4: Hiccup ends on the 8th `ss_tick` pulse; seven pulses are not enough. On the clock after that 8th tick is sampled, `hiccup` falls, `hs_en`/`ls_en` return high and `ss_restart` is high for exactly one clock. All fault counters start again from zero.
- R5: When 4 consecutive periods each hold at least one `neg_trip`, the closing `cyc_start` gives negative shutdown. In negative shutdown, `hs_en`=0, `ls_en`=0, `dis_en`=1, `fault_active`=1 and `hiccup`=0.
- R6: A period with no `neg_trip` clears the negative-current run. Three trip periods, one clean period and three more trip periods do not cause shutdown.
- R7: During negative shutdown, `dis_en` drops in the same clock that `in_reg` is high. On the next clock, switching resumes with `pfm_mode`=1 and `fault_active`=0.
- R8: After negative-shutdown recovery, `pfm_mode` stays high through 19 `us_tick` pulses and falls in the clock after the 20th pulse is sampled.
- R9: `dis_en` and `ls_en` are never high together. `fault_active` is high exactly in hiccup or in negative shutdown.
- R10: After reset: `hs_en`=1, `ls_en`=1, and `dis_en`, `hiccup`, `ss_restart`, `pfm_mode` and `fault_active` are all 0. In normal operation, `ss_tick`, `in_reg` and `us_tick` have no effect on the outputs while no PFM dwell is running.
- R11: When both limits are reached at the same period close, overcurrent wins. The block enters hiccup with `dis_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | One-clock pulse at the start of each switching period |
| oc_trip | input | 1 | High-side overcurrent comparator flag |
| neg_trip | input | 1 | Low-side negative valley comparator flag |
| ss_tick | input | 1 | One-clock pulse per soft-start period |
| in_reg | input | 1 | Output within regulation window |
| us_tick | input | 1 | One-clock pulse per microsecond |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| dis_en | output | 1 | Output discharge switch enable |
| hiccup | output | 1 | Overcurrent hiccup hold active |
| ss_restart | output | 1 | One-clock soft-start restart request |
| pfm_mode | output | 1 | Forced PFM dwell active |
| fault_active | output | 1 | Hiccup or negative shutdown active |

## Verification
Gate blanking on a trip and the drop of `dis_en` when `in_reg` rises are combinational, so the bench checks them a moment after driving the input, in the same clock. State changes (hiccup entry, shutdown entry, recovery, end of PFM dwell) and the `ss_restart` pulse appear one clock after the deciding `cyc_start`, `ss_tick`, `in_reg` or `us_tick` is sampled. The bench drives inputs on falling edges and reads each result at the falling edge that follows that rising edge. Boundary counts (16 against 17 periods, 3 against 4, 7 against 8 ticks, 19 against 20 microseconds) are checked on both sides.

// File: rtl/cycle_fault_ctrl.sv
module cycle_fault_ctrl #(
  parameter int OC_LIMIT       = 17,
  parameter int HICCUP_PERIODS = 8,
  parameter int NEG_LIMIT      = 4,
  parameter int PFM_DWELL_US   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic oc_trip,
  input  logic neg_trip,
  input  logic ss_tick,
  input  logic in_reg,
  input  logic us_tick,
  output logic hs_en,
  output logic ls_en,
  output logic dis_en,
  output logic hiccup,
  output logic ss_restart,
  output logic pfm_mode,
  output logic fault_active
);
  localparam int OCW = $clog2(OC_LIMIT + 1);
  localparam int NGW = $clog2(NEG_LIMIT + 1);
  localparam int SSW = $clog2(HICCUP_PERIODS + 1);
  localparam int PFW = $clog2(PFM_DWELL_US + 1);

  typedef enum logic [1:0] {ST_RUN, ST_HICCUP, ST_NEGSD} st_t;

  st_t            state;
  logic           oc_seen, ng_seen;
  logic [OCW-1:0] oc_cnt;
  logic [NGW-1:0] ng_cnt;
  logic [SSW-1:0] ss_cnt;
  logic [PFW-1:0] pfm_cnt;

  wire run    = (state == ST_RUN);
  wire oc_hit = oc_seen && (oc_cnt == OCW'(OC_LIMIT - 1));
  wire ng_hit = ng_seen && (ng_cnt == NGW'(NEG_LIMIT - 1));

  assign hs_en        = run && !oc_seen && !oc_trip;
  assign ls_en        = run;
  assign dis_en       = (state == ST_NEGSD) && !in_reg;
  assign hiccup       = (state == ST_HICCUP);
  assign fault_active = !run;
  assign pfm_mode     = run && (pfm_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      oc_seen    <= 1'b0;
      ng_seen    <= 1'b0;
      oc_cnt     <= '0;
      ng_cnt     <= '0;
      ss_cnt     <= '0;
      pfm_cnt    <= '0;
      ss_restart <= 1'b0;
    end else begin
      ss_restart <= 1'b0;
      case (state)
        ST_RUN: begin
          if (us_tick && pfm_cnt != '0) pfm_cnt <= pfm_cnt - 1'b1;
          if (cyc_start) begin
            oc_seen <= oc_trip;
            ng_seen <= neg_trip;
            oc_cnt  <= oc_seen ? oc_cnt + 1'b1 : '0;
            ng_cnt  <= ng_seen ? ng_cnt + 1'b1 : '0;
            if (oc_hit) begin
              state   <= ST_HICCUP;
              pfm_cnt <= '0;
            end else if (ng_hit) begin
              state   <= ST_NEGSD;
              pfm_cnt <= '0;
            end
          end else begin
            oc_seen <= oc_seen | oc_trip;
            ng_seen <= ng_seen | neg_trip;
          end
        end
        ST_HICCUP: begin
          if (ss_tick) begin
            if (ss_cnt == SSW'(HICCUP_PERIODS - 1)) begin
              state      <= ST_RUN;
              ss_cnt     <= '0;
              oc_cnt     <= '0;
              ng_cnt     <= '0;
              oc_seen    <= 1'b0;
              ng_seen    <= 1'b0;
              ss_restart <= 1'b1;
            end else begin
              ss_cnt <= ss_cnt + 1'b1;
            end
          end
        end
        ST_NEGSD: begin
          if (in_reg) begin
            state   <= ST_RUN;
            oc_cnt  <= '0;
            ng_cnt  <= '0;
            oc_seen <= 1'b0;
            ng_seen <= 1'b0;
            pfm_cnt <= PFW'(PFM_DWELL_US);
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

module cycle_fault_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cyc_start,
  input logic in_reg,
  input logic hs_en,
  input logic ls_en,
  input logic dis_en,
  input logic hiccup,
  input logic ss_restart,
  input logic pfm_mode,
  input logic fault_active
);
  assert_blank_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_en && !fault_active && !cyc_start) |=> !hs_en);
  assert_hiccup_on_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hiccup) |-> $past(cyc_start));
  assert_restart_from_hiccup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |-> $past(hiccup));
  assert_restart_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> !ss_restart);
  assert_discharge_in_negsd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dis_en |-> (fault_active && !hiccup && !hs_en));
  assert_discharge_off_in_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_reg |-> !dis_en);
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(dis_en && ls_en));
  assert_fault_gates_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_active |-> (!ls_en && !hs_en));
  assert_pfm_only_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pfm_mode |-> !fault_active);
endmodule

bind cycle_fault_ctrl cycle_fault_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .in_reg(in_reg),
  .hs_en(hs_en), .ls_en(ls_en), .dis_en(dis_en), .hiccup(hiccup),
  .ss_restart(ss_restart), .pfm_mode(pfm_mode), .fault_active(fault_active)
);

// File: tb/sim_cycle_fault_ctrl.sv
`timescale 1ns/1ps
module sim_cycle_fault_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_start = 0, oc_trip = 0, neg_trip = 0, ss_tick = 0, in_reg = 0, us_tick = 0;
  logic hs_en, ls_en, dis_en, hiccup, ss_restart, pfm_mode, fault_active;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  cycle_fault_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .oc_trip(oc_trip),
    .neg_trip(neg_trip), .ss_tick(ss_tick), .in_reg(in_reg), .us_tick(us_tick),
    .hs_en(hs_en), .ls_en(ls_en), .dis_en(dis_en), .hiccup(hiccup),
    .ss_restart(ss_restart), .pfm_mode(pfm_mode), .fault_active(fault_active)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cyc_start = 0; oc_trip = 0; neg_trip = 0;
    ss_tick = 0; in_reg = 0; us_tick = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic begin_cycle();
    @(negedge clk); cyc_start = 1;
    @(negedge clk); cyc_start = 0;
    #0.5;
  endtask

  task automatic cycle_body(input logic oc, input logic ng);
    @(negedge clk); oc_trip = oc; neg_trip = ng;
    @(negedge clk); oc_trip = 0; neg_trip = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_cycles(input int n, input logic oc, input logic ng);
    for (int i = 0; i < n; i++) begin
      begin_cycle();
      cycle_body(oc, ng);
    end
  endtask

  task automatic pulse_ss();
    @(negedge clk); ss_tick = 1;
    @(negedge clk); ss_tick = 0;
    #0.5;
  endtask

  task automatic pulse_us();
    @(negedge clk); us_tick = 1;
    @(negedge clk); us_tick = 0;
    #0.5;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10", "hs_en", hs_en, 1); chk("R10", "ls_en", ls_en, 1);
    chk("R10", "dis_en", dis_en, 0); chk("R10", "hiccup", hiccup, 0);
    chk("R10", "ss_restart", ss_restart, 0); chk("R10", "pfm_mode", pfm_mode, 0);
    chk("R10", "fault_active", fault_active, 0);
    pulse_ss(); pulse_us();
    @(negedge clk); in_reg = 1; @(negedge clk); in_reg = 0; #0.5;
    chk("R10", "ignored ticks hs_en", hs_en, 1);
    chk("R10", "ignored ticks fault", fault_active, 0);
    chk("R10", "ignored ticks pfm", pfm_mode, 0);
  endtask

  task automatic t_blank();
    do_reset();
    begin_cycle();
    @(negedge clk); oc_trip = 1; #0.5;
    chk("R1", "hs_en during trip", hs_en, 0);
    @(negedge clk); oc_trip = 0; #0.5;
    chk("R1", "hs_en after trip", hs_en, 0);
    repeat (2) @(negedge clk); #0.5;
    chk("R1", "hs_en rest of period", hs_en, 0);
    begin_cycle();
    chk("R1", "hs_en next period", hs_en, 1);
  endtask

  task automatic t_oc_limit();
    do_reset();
    run_cycles(16, 1, 0);
    begin_cycle();
    chk("R2", "no hiccup after 16", hiccup, 0);
    cycle_body(1, 0);
    begin_cycle();
    chk("R2", "hiccup after 17", hiccup, 1);
    chk("R2", "fault_active", fault_active, 1);
    chk("R2", "hs_en", hs_en, 0); chk("R2", "ls_en", ls_en, 0);
  endtask

  task automatic t_hiccup();
    repeat (7) pulse_ss();
    chk("R4", "still hiccup after 7", hiccup, 1);
    chk("R4", "no restart after 7", ss_restart, 0);
    pulse_ss();
    chk("R4", "hiccup ends", hiccup, 0);
    chk("R4", "ss_restart pulse", ss_restart, 1);
    chk("R4", "hs_en back", hs_en, 1); chk("R4", "ls_en back", ls_en, 1);
    @(negedge clk); #0.5;
    chk("R4", "ss_restart single", ss_restart, 0);
    run_cycles(16, 1, 0);
    begin_cycle();
    chk("R4", "counters cleared", hiccup, 0);
  endtask

  task automatic t_oc_reset();
    do_reset();
    run_cycles(16, 1, 0);
    run_cycles(1, 0, 0);
    run_cycles(16, 1, 0);
    begin_cycle();
    chk("R3", "clean period clears run", hiccup, 0);
  endtask

  task automatic t_neg();
    do_reset();
    run_cycles(3, 0, 1);
    begin_cycle();
    chk("R5", "no shutdown after 3", fault_active, 0);
    cycle_body(0, 1);
    begin_cycle();
    chk("R5", "fault_active", fault_active, 1); chk("R5", "dis_en", dis_en, 1);
    chk("R5", "hs_en", hs_en, 0); chk("R5", "ls_en", ls_en, 0);
    chk("R5", "hiccup", hiccup, 0);
    chk("R9", "no overlap", dis_en & ls_en, 0);
  endtask

  task automatic t_recover();
    @(negedge clk); in_reg = 1; #0.5;
    chk("R7", "dis_en drops at once", dis_en, 0);
    @(negedge clk); in_reg = 0; #0.5;
    chk("R7", "switching resumes", hs_en, 1);
    chk("R7", "pfm entered", pfm_mode, 1);
    chk("R7", "fault cleared", fault_active, 0);
    repeat (19) pulse_us();
    chk("R8", "pfm after 19 us", pfm_mode, 1);
    pulse_us();
    chk("R8", "pfm ends after 20 us", pfm_mode, 0);
  endtask

  task automatic t_neg_reset();
    do_reset();
    run_cycles(3, 0, 1);
    run_cycles(1, 0, 0);
    run_cycles(3, 0, 1);
    begin_cycle();
    chk("R6", "clean period clears neg run", fault_active, 0);
  endtask

  task automatic t_both();
    do_reset();
    run_cycles(13, 1, 0);
    run_cycles(4, 1, 1);
    begin_cycle();
    chk("R11", "hiccup wins", hiccup, 1);
    chk("R11", "no discharge", dis_en, 0);
    chk("R9", "fault_active in hiccup", fault_active, 1);
  endtask

  initial begin
    t_reset();
    t_blank();
    t_oc_limit();
    t_hiccup();
    t_oc_reset();
    t_neg();
    t_recover();
    t_neg_reset();
    t_both();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule